// File: doc/BRIEF.md
# Configuration Test Access Port

This block is the IEEE 1149.1 test access port of a small configurable supply-monitoring device. A 16-state controller, advanced by TMS on rising TCK edges, walks between an instruction path and a data path. The 6-bit instruction register picks which data register sits between TDI and TDO. Beside the standard bypass and identification registers, the port offers five writable configuration registers and a read-only snapshot of six comparator outputs. Writable registers present their held contents on output ports, so the rest of the device can use them.

Three programming-related instructions drive a safe-state flag that holds the device outputs at a defined level. A host loads one of these instructions before it touches the programmable array. Any test reset releases the flag again.

All data shifts least significant bit first. TDO is launched on the falling edge of TCK. A separate enable output marks when TDO should be driven rather than left floating.

Top module: `cfg_tap_ctrl`

## Requirements
- R1: The controller follows the standard 16-state TAP transition graph on each rising TCK edge. Five consecutive TCK cycles with TMS high reach Test-Logic-Reset from any state. Leaving Pause-DR through Exit2-DR with TMS low resumes shifting without losing bits.
- R2: While trst_ni is low, and in every cycle spent in Test-Logic-Reset, the instruction becomes IDCODE, safe_o is low and tdo_en_o is low. The held configuration registers are cleared by trst_ni only; a TMS-driven reset leaves them unchanged.
- R3: Capture-IR loads the pattern 000001 into the instruction shift stage, which shifts LSB first. A new instruction takes effect only at the rising edge that leaves Update-IR.
- R4: BYPASS (111111), EXTEST (000000), program-enable (001000), discharge (001001) and every code not listed in R5 to R7 select a 1-bit bypass register. Bypass captures 0, so the TDI stream comes out delayed by one TCK.
- R5: IDCODE (000001) selects a 32-bit register that captures the identification parameter, whose bit 0 is 1.
- R6: The writable registers have these codes and widths: signature 000010 (16 bits), configuration address 000011 (4 bits), configuration data 000100 (17 bits), array address 000101 (43 bits) and array data 000110 (41 bits). Capture-DR loads the register's held value. Update-DR stores the shifted bits, and the held value appears on the matching output port.
- R7: STATUS (000111) captures comp_i (6 bits) in Capture-DR. Update-DR with STATUS selected changes no held register.
- R8: In Shift-DR, TDI enters at the most significant bit of the selected register and bit 0 goes to TDO. Shifting one bit more than the register width returns the first TDI bit.
- R9: safe_o is high exactly while the active instruction is array address (000101), program-enable (001000) or discharge (001001).
- R10: tdo_o and tdo_en_o change on the falling TCK edge. tdo_en_o is high only in Shift-IR and Shift-DR, and tdo_o then carries bit 0 of the active shift stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| trst_ni | input | 1 | Asynchronous test reset, active low |
| tms_i | input | 1 | Test mode select, sampled on rising TCK |
| tdi_i | input | 1 | Serial test data in |
| comp_i | input | 6 | Comparator outputs captured by STATUS |
| tdo_o | output | 1 | Serial test data out, launched on falling TCK |
| tdo_en_o | output | 1 | High while tdo_o should be driven |
| safe_o | output | 1 | Forces device outputs to their safe level |
| sig_o | output | 16 | Held signature register |
| cfg_data_o | output | 17 | Held configuration data register |
| cfg_addr_o | output | 4 | Held configuration address register |
| arr_data_o | output | 41 | Held array data register |
| arr_addr_o | output | 43 | Held array address register |

## Verification
Several rules are checked by the assertions on every cycle: Test-Logic-Reset holds under TMS high, five high TMS cycles force that state, the instruction changes only at Update-IR, and safe_o rises only after Update-IR. The same goes for the one-bit data shift, the read-only status update, the signature update and TDO launch only in the shift states. Other behaviour only the bench scenarios can show. These include the exact code-to-register mapping over all 64 codes, each register's width measured by an overlong shift, and read-back of written values. They also include comparator capture for all 64 input patterns, the split shift through Pause-DR, and held registers surviving a TMS reset but not trst_ni.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

    localparam int IR_W = 6;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        SEL_BYP, SEL_ID, SEL_SIG, SEL_CFGA, SEL_CFGD, SEL_ARRA, SEL_ARRD, SEL_STAT
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST   = 6'h00;
    localparam logic [IR_W-1:0] OP_IDCODE   = 6'h01;
    localparam logic [IR_W-1:0] OP_SIG      = 6'h02;
    localparam logic [IR_W-1:0] OP_CFG_ADDR = 6'h03;
    localparam logic [IR_W-1:0] OP_CFG_DATA = 6'h04;
    localparam logic [IR_W-1:0] OP_ARR_ADDR = 6'h05;
    localparam logic [IR_W-1:0] OP_ARR_DATA = 6'h06;
    localparam logic [IR_W-1:0] OP_STATUS   = 6'h07;
    localparam logic [IR_W-1:0] OP_PROG_EN  = 6'h08;
    localparam logic [IR_W-1:0] OP_DISCHG   = 6'h09;
    localparam logic [IR_W-1:0] OP_BYPASS   = 6'h3F;

    localparam logic [IR_W-1:0] IR_CAPTURE  = 6'b000001;

    function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
        case (op)
            OP_IDCODE:   return SEL_ID;
            OP_SIG:      return SEL_SIG;
            OP_CFG_ADDR: return SEL_CFGA;
            OP_CFG_DATA: return SEL_CFGD;
            OP_ARR_ADDR: return SEL_ARRA;
            OP_ARR_DATA: return SEL_ARRD;
            OP_STATUS:   return SEL_STAT;
            default:     return SEL_BYP;
        endcase
    endfunction

    function automatic logic is_safe_op(input logic [IR_W-1:0] op);
        return (op == OP_ARR_ADDR) || (op == OP_PROG_EN) || (op == OP_DISCHG);
    endfunction

    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
    import cfg_tap_pkg::*;
(
    input  logic       tck_i,
    input  logic       trst_ni,
    input  logic       tms_i,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_TLR:    d.st = tms_i ? ST_TLR    : ST_RTI;
            ST_RTI:    d.st = tms_i ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: d.st = tms_i ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: d.st = tms_i ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  d.st = tms_i ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: d.st = tms_i ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  d.st = tms_i ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: d.st = tms_i ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: d.st = tms_i ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: d.st = tms_i ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: d.st = tms_i ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  d.st = tms_i ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: d.st = tms_i ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  d.st = tms_i ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: d.st = tms_i ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: d.st = tms_i ? ST_SEL_DR : ST_RTI;
            default:   d.st = ST_TLR;
        endcase
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) q <= '{st: ST_TLR};
        else          q <= d;
    end

    assign state_o = q.st;

    // R1
    tlr_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (q.st == ST_TLR && tms_i) |=> (q.st == ST_TLR));

    // R1
    five_high_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
        |=> (q.st == ST_TLR));

endmodule

// File: rtl/cfg_tap_ir.sv
module cfg_tap_ir
    import cfg_tap_pkg::*;
(
    input  logic            tck_i,
    input  logic            trst_ni,
    input  logic            tdi_i,
    input  tap_state_e      state_i,
    output logic [IR_W-1:0] ir_o,
    output logic            lsb_o,
    output logic            safe_o
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] ir;
    } ir_regs_t;

    ir_regs_t d, q;

    always_comb begin
        d = q;
        case (state_i)
            ST_TLR:    d.ir = OP_IDCODE;
            ST_CAP_IR: d.sh = IR_CAPTURE;
            ST_SH_IR:  d.sh = {tdi_i, q.sh[IR_W-1:1]};
            ST_UPD_IR: d.ir = q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) q <= '{sh: '0, ir: OP_IDCODE};
        else          q <= d;
    end

    assign ir_o   = q.ir;
    assign lsb_o  = q.sh[0];
    assign safe_o = is_safe_op(q.ir);

    // R3
    ir_update_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == ST_UPD_IR) |=> (q.ir == $past(q.sh)));

    // R3
    ir_stable_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(q.ir));

    // R9
    safe_rise_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $rose(safe_o) |-> ($past(state_i) == ST_UPD_IR));

endmodule

// File: rtl/cfg_tap_dr.sv
module cfg_tap_dr
    import cfg_tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h1A5C_0043,
    parameter int          SIG_W    = 16,
    parameter int          CFGD_W   = 17,
    parameter int          CFGA_W   = 4,
    parameter int          ARRD_W   = 41,
    parameter int          ARRA_W   = 43,
    parameter int          STAT_W   = 6
) (
    input  logic              tck_i,
    input  logic              trst_ni,
    input  logic              tdi_i,
    input  tap_state_e        state_i,
    input  logic [IR_W-1:0]   ir_i,
    input  logic [STAT_W-1:0] comp_i,
    output logic              lsb_o,
    output logic [SIG_W-1:0]  sig_o,
    output logic [CFGD_W-1:0] cfgd_o,
    output logic [CFGA_W-1:0] cfga_o,
    output logic [ARRD_W-1:0] arrd_o,
    output logic [ARRA_W-1:0] arra_o
);

    localparam int SR_W  = int'(wmax(wmax(wmax(32, SIG_W), wmax(CFGD_W, CFGA_W)),
                                     wmax(wmax(ARRD_W, ARRA_W), STAT_W)));
    localparam int IDX_W = $clog2(SR_W);

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [SIG_W-1:0]  sig;
        logic [CFGD_W-1:0] cfgd;
        logic [CFGA_W-1:0] cfga;
        logic [ARRD_W-1:0] arrd;
        logic [ARRA_W-1:0] arra;
    } dr_regs_t;

    dr_regs_t         d, q;
    dr_sel_e          sel;
    logic [IDX_W-1:0] top_idx;
    logic [SR_W-1:0]  cap;

    assign sel = decode_dr(ir_i);

    always_comb begin
        cap = '0;
        case (sel)
            SEL_ID:   begin cap[31:0]       = ID_VALUE; top_idx = IDX_W'(31);         end
            SEL_SIG:  begin cap[SIG_W-1:0]  = q.sig;    top_idx = IDX_W'(SIG_W - 1);  end
            SEL_CFGA: begin cap[CFGA_W-1:0] = q.cfga;   top_idx = IDX_W'(CFGA_W - 1); end
            SEL_CFGD: begin cap[CFGD_W-1:0] = q.cfgd;   top_idx = IDX_W'(CFGD_W - 1); end
            SEL_ARRA: begin cap[ARRA_W-1:0] = q.arra;   top_idx = IDX_W'(ARRA_W - 1); end
            SEL_ARRD: begin cap[ARRD_W-1:0] = q.arrd;   top_idx = IDX_W'(ARRD_W - 1); end
            SEL_STAT: begin cap[STAT_W-1:0] = comp_i;   top_idx = IDX_W'(STAT_W - 1); end
            default:  top_idx = '0;
        endcase
    end

    always_comb begin
        d = q;
        case (state_i)
            ST_CAP_DR: d.sr = cap;
            ST_SH_DR: begin
                d.sr          = q.sr >> 1;
                d.sr[top_idx] = tdi_i;
            end
            ST_UPD_DR: begin
                case (sel)
                    SEL_SIG:  d.sig  = q.sr[SIG_W-1:0];
                    SEL_CFGA: d.cfga = q.sr[CFGA_W-1:0];
                    SEL_CFGD: d.cfgd = q.sr[CFGD_W-1:0];
                    SEL_ARRA: d.arra = q.sr[ARRA_W-1:0];
                    SEL_ARRD: d.arrd = q.sr[ARRD_W-1:0];
                    default:  ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) q <= '0;
        else          q <= d;
    end

    assign lsb_o  = q.sr[0];
    assign sig_o  = q.sig;
    assign cfgd_o = q.cfgd;
    assign cfga_o = q.cfga;
    assign arrd_o = q.arrd;
    assign arra_o = q.arra;

    // R7
    status_ro_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == ST_UPD_DR && sel == SEL_STAT)
        |=> ($stable(q.sig) && $stable(q.cfgd) && $stable(q.cfga) && $stable(q.arrd) && $stable(q.arra)));

    // R7
    status_cap_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == ST_CAP_DR && sel == SEL_STAT) |=> (q.sr[STAT_W-1:0] == $past(comp_i)));

    // R8
    shift_step_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == ST_SH_DR && sel != SEL_BYP) |=> (q.sr[0] == $past(q.sr[1])));

    // R6
    sig_update_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == ST_UPD_DR && sel == SEL_SIG) |=> (q.sig == $past(q.sr[SIG_W-1:0])));

endmodule

// File: rtl/cfg_tap_ctrl.sv
module cfg_tap_ctrl
    import cfg_tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h1A5C_0043,
    parameter int          SIG_W    = 16,
    parameter int          CFGD_W   = 17,
    parameter int          CFGA_W   = 4,
    parameter int          ARRD_W   = 41,
    parameter int          ARRA_W   = 43,
    parameter int          STAT_W   = 6
) (
    input  logic              tck_i,
    input  logic              trst_ni,
    input  logic              tms_i,
    input  logic              tdi_i,
    input  logic [STAT_W-1:0] comp_i,
    output logic              tdo_o,
    output logic              tdo_en_o,
    output logic              safe_o,
    output logic [SIG_W-1:0]  sig_o,
    output logic [CFGD_W-1:0] cfg_data_o,
    output logic [CFGA_W-1:0] cfg_addr_o,
    output logic [ARRD_W-1:0] arr_data_o,
    output logic [ARRA_W-1:0] arr_addr_o
);

    tap_state_e      state;
    logic [IR_W-1:0] ir;
    logic            ir_lsb;
    logic            dr_lsb;

    cfg_tap_fsm u_fsm (
        .tck_i   (tck_i),
        .trst_ni (trst_ni),
        .tms_i   (tms_i),
        .state_o (state)
    );

    cfg_tap_ir u_ir (
        .tck_i   (tck_i),
        .trst_ni (trst_ni),
        .tdi_i   (tdi_i),
        .state_i (state),
        .ir_o    (ir),
        .lsb_o   (ir_lsb),
        .safe_o  (safe_o)
    );

    cfg_tap_dr #(
        .ID_VALUE (ID_VALUE),
        .SIG_W    (SIG_W),
        .CFGD_W   (CFGD_W),
        .CFGA_W   (CFGA_W),
        .ARRD_W   (ARRD_W),
        .ARRA_W   (ARRA_W),
        .STAT_W   (STAT_W)
    ) u_dr (
        .tck_i   (tck_i),
        .trst_ni (trst_ni),
        .tdi_i   (tdi_i),
        .state_i (state),
        .ir_i    (ir),
        .comp_i  (comp_i),
        .lsb_o   (dr_lsb),
        .sig_o   (sig_o),
        .cfgd_o  (cfg_data_o),
        .cfga_o  (cfg_addr_o),
        .arrd_o  (arr_data_o),
        .arra_o  (arr_addr_o)
    );

    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    out_regs_t d, q;

    always_comb begin
        d.en  = (state == ST_SH_IR) || (state == ST_SH_DR);
        d.tdo = (state == ST_SH_IR) ? ir_lsb : dr_lsb;
    end

    always_ff @(negedge tck_i or negedge trst_ni) begin
        if (!trst_ni) q <= '0;
        else          q <= d;
    end

    assign tdo_o    = q.tdo;
    assign tdo_en_o = q.en;

    // R10
    tdo_en_state_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        tdo_en_o |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R10
    tdo_dr_bit_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (tdo_en_o && state == ST_SH_DR) |-> (tdo_o == dr_lsb));

endmodule

// File: tb/cfg_tap_ctrl_tb_top.sv
module cfg_tap_ctrl_tb_top;

    localparam int TCK_PERIOD = 20;
    localparam logic [31:0] ID_EXP = 32'h1A5C_0043;

    localparam logic [5:0] C_IDCODE = 6'h01, C_SIG = 6'h02, C_CFGA = 6'h03, C_CFGD = 6'h04,
                           C_ARRA = 6'h05, C_ARRD = 6'h06, C_STAT = 6'h07,
                           C_PROG = 6'h08, C_DIS = 6'h09, C_BYP = 6'h3F;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [5:0]  comp = '0;
    logic        tdo, tdo_en, safe;
    logic [15:0] sig;
    logic [16:0] cfgd;
    logic [3:0]  cfga;
    logic [40:0] arrd;
    logic [42:0] arra;

    int n_chk  = 0;
    int n_fail = 0;

    always #(TCK_PERIOD / 2) tck = ~tck;

    cfg_tap_ctrl #(
        .ID_VALUE (ID_EXP), .SIG_W (16), .CFGD_W (17), .CFGA_W (4),
        .ARRD_W (41), .ARRA_W (43), .STAT_W (6)
    ) dut_i (
        .tck_i (tck), .trst_ni (trst_n), .tms_i (tms), .tdi_i (tdi), .comp_i (comp),
        .tdo_o (tdo), .tdo_en_o (tdo_en), .safe_o (safe),
        .sig_o (sig), .cfg_data_o (cfgd), .cfg_addr_o (cfga),
        .arr_data_o (arrd), .arr_addr_o (arra)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one TCK: sample outputs for the current state, then drive TMS/TDI for the next rising edge
    task automatic tick(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #(TCK_PERIOD / 4);
        o   = tdo;
        e   = tdo_en;
        tms = m;
        tdi = d;
    endtask

    task automatic step(input logic m);
        logic o, e;
        tick(m, 1'b0, o, e);
    endtask

    // from Run-Test/Idle back to Run-Test/Idle with the update visible
    task automatic shift_ir(input logic [5:0] code, output logic [5:0] cap, output logic safe_x1);
        logic o, e;
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < 6; i++) begin
            tick(i == 5, code[i], o, e);
            cap[i] = o;
        end
        step(1);
        safe_x1 = safe;
        step(0); step(0);
    endtask

    task automatic shift_dr(input int len, input logic [63:0] din,
                            output logic [63:0] dout, output logic en_ok);
        logic o, e;
        dout  = '0;
        en_ok = 1'b1;
        step(1); step(0); step(0);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o, e);
            dout[i] = o;
            if (e !== 1'b1) en_ok = 1'b0;
        end
        step(1); step(0); step(0);
    endtask

    function automatic logic [5:0] reg_code(input int i);
        case (i)
            0: return C_SIG;
            1: return C_CFGA;
            2: return C_CFGD;
            3: return C_ARRA;
            default: return C_ARRD;
        endcase
    endfunction

    function automatic int reg_w(input int i);
        case (i)
            0: return 16;
            1: return 4;
            2: return 17;
            3: return 43;
            default: return 41;
        endcase
    endfunction

    function automatic logic [63:0] port_val(input int i);
        case (i)
            0: return 64'(sig);
            1: return 64'(cfga);
            2: return 64'(cfgd);
            3: return 64'(arra);
            default: return 64'(arrd);
        endcase
    endfunction

    logic [63:0] hold_exp [5];

    initial begin
        #(TCK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] out;
        logic        en_ok;
        logic [5:0]  cap;
        logic        sx1;
        logic        prev_safe;
        logic        o, e;

        for (int i = 0; i < 5; i++) hold_exp[i] = '0;
        repeat (3) @(negedge tck);
        #(TCK_PERIOD / 4);
        trst_n = 1'b1;

        // R2 reset state at the ports
        check("R2 tdo_en after reset", 64'(tdo_en), 64'd0);
        check("R2 safe after reset", 64'(safe), 64'd0);
        for (int i = 0; i < 5; i++) check("R2 held register after reset", port_val(i), 64'd0);

        step(0);
        // R5 default instruction is IDCODE
        shift_dr(32, 64'h0, out, en_ok);
        check("R5 IDCODE after reset", out, 64'(ID_EXP));
        check("R10 tdo_en during Shift-DR", 64'(en_ok), 64'd1);
        tick(0, 0, o, e);
        check("R10 tdo_en in Run-Test/Idle", 64'(e), 64'd0);

        // R3 capture pattern; R9 sweep of all codes; R4 bypass codes
        prev_safe = 1'b0;
        for (int c = 0; c < 64; c++) begin
            logic [5:0] code;
            logic       exp_safe;
            code     = 6'(c);
            exp_safe = (code == C_ARRA) || (code == C_PROG) || (code == C_DIS);
            shift_ir(code, cap, sx1);
            check("R3 IR capture pattern", 64'(cap), 64'h01);
            check("R3 no effect before Update-IR", 64'(sx1), 64'(prev_safe));
            check("R9 safe per code", 64'(safe), 64'(exp_safe));
            prev_safe = exp_safe;
            if (code > 6'h07 || code == 6'h00) begin
                logic [63:0] pat;
                pat = 64'((c * 37 + 11) & 8'hFF);
                shift_dr(8, pat, out, en_ok);
                check("R4 bypass one-cycle delay", out[7:0], {56'd0, pat[6:0], 1'b0});
            end
        end
        for (int i = 0; i < 5; i++) check("R4 bypass writes nothing", port_val(i), 64'd0);

        // R6 write and read back each writable register
        for (int i = 0; i < 5; i++) begin
            logic [63:0] mask;
            mask = (64'd1 << reg_w(i)) - 64'd1;
            shift_ir(reg_code(i), cap, sx1);
            for (int k = 0; k < 3; k++) begin
                logic [63:0] pat;
                pat = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1) ^ 64'(i * 12345)) & mask;
                shift_dr(reg_w(i), pat, out, en_ok);
                check("R6 capture returns held value", out & mask, hold_exp[i]);
                check("R6 held value on port", port_val(i), pat);
                hold_exp[i] = pat;
            end
            // R8 overlong shift measures width
            shift_dr(reg_w(i) + 1, 64'h1 | (64'h5 << 1), out, en_ok);
            check("R8 register contents lead", out & mask, hold_exp[i]);
            check("R8 first TDI bit after width", 64'(out[reg_w(i)]), 64'd1);
            hold_exp[i] = 64'h5;
            check("R8 stored top bits", port_val(i), 64'h5);
        end

        // R7 status capture for every comparator pattern, update ignored
        shift_ir(C_STAT, cap, sx1);
        for (int c = 0; c < 64; c++) begin
            comp = 6'(c);
            shift_dr(6, 64'(~c & 63), out, en_ok);
            check("R7 status capture", out, 64'(c));
        end
        for (int i = 0; i < 5; i++) check("R7 status update changes no register", port_val(i), hold_exp[i]);

        // R1 pause and resume in the data path
        shift_ir(C_CFGA, cap, sx1);
        step(1); step(0); step(0);
        tick(0, 1'b0, o, e);
        tick(1, 1'b1, o, e);
        tick(0, 1'b0, o, e);
        tick(0, 1'b0, o, e);
        check("R10 tdo_en low in Pause-DR", 64'(e), 64'd0);
        step(1);
        step(0);
        tick(0, 1'b1, o, e);
        tick(1, 1'b1, o, e);
        step(1); step(0); step(0);
        check("R1 resume after Pause-DR", 64'(cfga), 64'hE);
        hold_exp[1] = 64'hE;

        // R2 TMS reset releases safe state and keeps held registers
        shift_ir(C_PROG, cap, sx1);
        check("R9 program-enable sets safe", 64'(safe), 64'd1);
        repeat (5) step(1);
        step(0);
        check("R2 TMS reset releases safe", 64'(safe), 64'd0);
        for (int i = 0; i < 5; i++) check("R2 TMS reset keeps held register", port_val(i), hold_exp[i]);
        shift_dr(32, 64'h0, out, en_ok);
        check("R1 five TMS-high cycles load IDCODE", out, 64'(ID_EXP));

        // R2 asynchronous test reset
        shift_ir(C_DIS, cap, sx1);
        check("R9 discharge sets safe", 64'(safe), 64'd1);
        #(TCK_PERIOD / 8);
        trst_n = 1'b0;
        #1;
        check("R2 trst releases safe", 64'(safe), 64'd0);
        for (int i = 0; i < 5; i++) check("R2 trst clears held register", port_val(i), 64'd0);
        step(1);
        trst_n = 1'b1;
        step(0);
        shift_dr(32, 64'h0, out, en_ok);
        check("R5 IDCODE after trst", out, 64'(ID_EXP));

        summary();
    end

endmodule